// File: doc/BRIEF.md
# MDIO Management Responder with Register Bus Bridge

This block sits on the PHY side of a two-wire management link. It samples the MDC clock and MDIO data lines and recognises frames in both the short-address format (start `01`) and the extended-address format (start `00`). It reacts only to frames that carry its own port address, given on `phy_addr`. A frame from the host is turned into a single bus cycle on a simple strobe/acknowledge register bus, and the block raises a one-cycle interrupt when a write cycle completes. The user register space behind the bus decides what each address holds. Writes to read-only or undefined locations must have no effect there.

For a read frame, the block fetches the addressed word over the bus while the turnaround bits are still arriving. It takes control of MDIO only for the second turnaround bit and the data bits, and releases the line otherwise so that the external pull-up holds it high. In the extended format, an address frame loads an internal 16-bit register pointer. Later write and read frames use that pointer, and one read opcode advances it after its data phase. MDC and MDIO are brought into the system clock domain by a short synchroniser. Each rising edge of MDC marks one bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive sampled ones followed by a 0. A frame with 31 preamble ones produces no bus cycle and no drive of MDIO, and a frame with exactly 32 preamble ones is accepted.
- R2: A short-format frame has start `01`, opcode (`01` = write), a 5-bit port address, a 5-bit register number, turnaround `10` and 16 data bits, all MSB first. When its port address matches, it produces exactly one bus write with `bus_c45`=0, `bus_dev`=0, `bus_adr` = the register number zero-extended, and `bus_wdat` = the data.
- R3: A frame whose port address differs from `phy_addr` produces no bus cycle, and MDIO is never driven during it.
- R4: A host-driven frame whose turnaround bits are not `10` is discarded. It produces no bus cycle and no interrupt, and an extended-format address frame with a bad turnaround leaves the pointer unchanged.
- R5: On a read frame, `mdio_oe` stays low for the first turnaround bit. The block drives 0 for the second turnaround bit, then the 16 data bits MSB first, and releases the line after the last data bit. Each output bit changes after a detected MDC rising edge.
- R6: `wr_irq` is a one-cycle pulse in the cycle after each acknowledged bus write, and only then.
- R7: An extended-format frame (start `00`) with opcode `00` loads its 16 data bits into the register pointer, with no bus cycle and no interrupt.
- R8: An extended-format frame with opcode `01` produces one bus write with `bus_c45`=1, `bus_dev` = the 5-bit device field (in the register-number position), and `bus_adr` = the pointer.
- R9: An extended-format read with opcode `11` reads at the pointer and leaves the pointer unchanged. Opcode `10` reads at the pointer and then adds one to it.
- R10: Short-format frames with opcode `00` or `11` are ignored: no bus cycle, and MDIO is not driven.
- R11: Once `bus_stb` is raised, it stays high with `bus_we`, `bus_dev`, `bus_adr` and `bus_wdat` stable until `bus_ack` is sampled high. Read data is taken from `bus_rdat` in that acknowledge cycle.
- R12: After reset, `mdio_oe`, `bus_stb` and `wr_irq` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr | input | 5 | Port address this responder answers to |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | Output enable for the MDIO tri-state buffer |
| bus_stb | output | 1 | Register bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_c45 | output | 1 | Cycle comes from an extended-format frame |
| bus_dev | output | 5 | Device field (extended format), otherwise 0 |
| bus_adr | output | 16 | Register address |
| bus_wdat | output | 16 | Write data |
| bus_rdat | input | 16 | Read data from the register space |
| bus_ack | input | 1 | Cycle completion from the register space |
| wr_irq | output | 1 | One-cycle pulse per completed write cycle |

## Verification
The hardest case to reach is the post-increment read. Its effect shows only on a later frame, so the stimulus chains an address frame, a write, two plain reads, an incrementing read and a follow-up read and write to the next location. The pointer therefore becomes visible at the bus and on MDIO. The preamble boundary is just as easy to blur, because leftover ones from the end of one frame can add to the next preamble. Every host frame therefore begins with a driven 0, so that 31 and 32 preamble ones are counted exactly.

// File: rtl/mdio_slv_pkg.sv
// Shared encodings for the MDIO responder: frame states, opcodes, turnaround code.
package mdio_slv_pkg;
    typedef enum logic [2:0] {
        FS_PRE,   // counting preamble ones
        FS_ST2,   // second start bit selects frame format
        FS_HDR,   // opcode, port address, register/device field
        FS_TA,    // turnaround
        FS_DAT    // data phase
    } frm_state_t;

    localparam logic [1:0] OP_C45_ADDR  = 2'b00;
    localparam logic [1:0] OP_WRITE     = 2'b01;
    localparam logic [1:0] OP_C22_READ  = 2'b10;
    localparam logic [1:0] OP_C45_RDINC = 2'b10;
    localparam logic [1:0] TA_WR_VALID  = 2'b10;
endpackage

// File: rtl/mdio_edge_sync.sv
// Brings MDC and MDIO into the clk domain through STAGES flops each and flags
// every MDC rising edge together with the data bit seen at that edge.
// Assumes MDC is much slower than clk (several clk periods per MDC phase).
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic bit_vld,
    output logic bit_val
);
    logic [STAGES:0]   mdc_pipe;
    logic [STAGES-1:0] dat_pipe;

    // Synchroniser chains; both take STAGES cycles so data stays aligned to the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_pipe <= '1;
            dat_pipe <= '1;
        end else begin
            mdc_pipe <= {mdc_pipe[STAGES-1:0], mdc};
            dat_pipe <= {dat_pipe[STAGES-2:0], mdio_in};
        end
    end

    assign bit_vld = mdc_pipe[STAGES-1] & ~mdc_pipe[STAGES];
    assign bit_val = dat_pipe[STAGES-1];
endmodule

// File: rtl/mdio_bus_master.sv
// Runs one strobe/acknowledge cycle per request, holds the request fields
// until acknowledged, captures read data, and pulses wr_irq after a write.
// Assumes the frame decoder never issues a new request while one is open.
module mdio_bus_master #(
    parameter int DW  = 16,
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_req,
    input  logic           wr_req,
    input  logic           req_c45,
    input  logic [RAW-1:0] req_dev,
    input  logic [DW-1:0]  req_adr,
    input  logic [DW-1:0]  req_wdat,
    input  logic           bus_ack,
    input  logic [DW-1:0]  bus_rdat,
    output logic           bus_stb,
    output logic           bus_we,
    output logic           bus_c45,
    output logic [RAW-1:0] bus_dev,
    output logic [DW-1:0]  bus_adr,
    output logic [DW-1:0]  bus_wdat,
    output logic [DW-1:0]  rd_data,
    output logic           wr_irq
);
    // Open a cycle on request, close it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_stb  <= 1'b0;
            bus_we   <= 1'b0;
            bus_c45  <= 1'b0;
            bus_dev  <= '0;
            bus_adr  <= '0;
            bus_wdat <= '0;
            rd_data  <= '0;
            wr_irq   <= 1'b0;
        end else begin
            wr_irq <= 1'b0;
            if (bus_stb) begin
                if (bus_ack) begin
                    bus_stb <= 1'b0;
                    if (bus_we) wr_irq  <= 1'b1;
                    else        rd_data <= bus_rdat;
                end
            end else if (rd_req || wr_req) begin
                bus_stb  <= 1'b1;
                bus_we   <= wr_req;
                bus_c45  <= req_c45;
                bus_dev  <= req_dev;
                bus_adr  <= req_adr;
                bus_wdat <= req_wdat;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
// Bit-level frame decoder and MDIO driver. Detects preamble and start,
// decodes both frame formats, filters on port address, checks the write
// turnaround, keeps the extended-format pointer and shifts read data out.
// Assumes one bit_vld pulse per MDC rising edge and read data ready before
// the second turnaround edge.
module mdio_frame_fsm
    import mdio_slv_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DW      = 16,
    parameter int PAW     = 5,
    parameter int RAW     = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_vld,
    input  logic           bit_val,
    input  logic [PAW-1:0] phy_addr,
    input  logic [DW-1:0]  rd_data,
    output logic           mdio_o,
    output logic           mdio_oe,
    output logic           rd_req,
    output logic           wr_req,
    output logic           req_c45,
    output logic [RAW-1:0] req_dev,
    output logic [DW-1:0]  req_adr,
    output logic [DW-1:0]  req_wdat
);
    localparam int HW  = 2 + PAW + RAW;
    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam int HCW = $clog2(HW);
    localparam int DCW = $clog2(DW);
    localparam logic [PCW-1:0] PRE_MAX = PCW'(PRE_LEN);
    localparam logic [HCW-1:0] HDR_END = HCW'(HW - 1);
    localparam logic [DCW-1:0] DAT_END = DCW'(DW - 1);

    frm_state_t     state;
    logic [PCW-1:0] pre_cnt;
    logic [HCW-1:0] hcnt;
    logic [DCW-1:0] dcnt;
    logic           tcnt;
    logic           is_c45;
    logic           is_rd;
    logic [HW-1:0]  hdr;
    logic [1:0]     ta;
    logic [1:0]     opq;
    logic [RAW-1:0] raq;
    logic [DW-1:0]  shreg;
    logic [DW-1:0]  ptr;

    logic [HW-1:0]  hdr_nxt;
    logic [1:0]     f_op;
    logic [PAW-1:0] f_pa;
    logic [RAW-1:0] f_ra;
    logic           f_ok;
    logic           f_rd;
    logic [DW-1:0]  dat_nxt;

    // Header field split and frame acceptance for the bit now arriving.
    always_comb begin
        hdr_nxt = {hdr[HW-2:0], bit_val};
        f_op    = hdr_nxt[HW-1 -: 2];
        f_pa    = hdr_nxt[RAW +: PAW];
        f_ra    = hdr_nxt[RAW-1:0];
        f_ok    = (f_pa == phy_addr) && (is_c45 || f_op == OP_WRITE || f_op == OP_C22_READ);
        f_rd    = is_c45 ? f_op[1] : (f_op == OP_C22_READ);
        dat_nxt = {shreg[DW-2:0], bit_val};
    end

    // Frame sequencer: advances one step per MDC rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FS_PRE;
            pre_cnt  <= '0;
            hcnt     <= '0;
            dcnt     <= '0;
            tcnt     <= 1'b0;
            is_c45   <= 1'b0;
            is_rd    <= 1'b0;
            hdr      <= '0;
            ta       <= '0;
            opq      <= '0;
            raq      <= '0;
            shreg    <= '0;
            ptr      <= '0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
            rd_req   <= 1'b0;
            wr_req   <= 1'b0;
            req_c45  <= 1'b0;
            req_dev  <= '0;
            req_adr  <= '0;
            req_wdat <= '0;
        end else begin
            rd_req <= 1'b0;
            wr_req <= 1'b0;
            if (bit_vld) begin
                unique case (state)
                    FS_PRE: begin
                        if (bit_val) begin
                            if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
                        end else begin
                            if (pre_cnt == PRE_MAX) state <= FS_ST2;
                            pre_cnt <= '0;
                        end
                    end
                    FS_ST2: begin
                        is_c45 <= ~bit_val;
                        hcnt   <= '0;
                        state  <= FS_HDR;
                    end
                    FS_HDR: begin
                        hdr  <= hdr_nxt;
                        hcnt <= hcnt + 1'b1;
                        if (hcnt == HDR_END) begin
                            if (f_ok) begin
                                opq   <= f_op;
                                raq   <= f_ra;
                                is_rd <= f_rd;
                                tcnt  <= 1'b0;
                                state <= FS_TA;
                                if (f_rd) begin
                                    rd_req  <= 1'b1;
                                    req_c45 <= is_c45;
                                    req_dev <= is_c45 ? f_ra : '0;
                                    req_adr <= is_c45 ? ptr : {{(DW-RAW){1'b0}}, f_ra};
                                end
                            end else begin
                                state <= FS_PRE;
                            end
                        end
                    end
                    FS_TA: begin
                        tcnt <= 1'b1;
                        dcnt <= '0;
                        if (is_rd) begin
                            if (!tcnt) begin
                                mdio_oe <= 1'b1;
                                mdio_o  <= 1'b0;
                            end else begin
                                mdio_o <= rd_data[DW-1];
                                shreg  <= {rd_data[DW-2:0], 1'b0};
                                state  <= FS_DAT;
                            end
                        end else begin
                            ta <= {ta[0], bit_val};
                            if (tcnt) state <= FS_DAT;
                        end
                    end
                    FS_DAT: begin
                        dcnt <= dcnt + 1'b1;
                        if (is_rd) begin
                            if (dcnt == DAT_END) begin
                                mdio_oe <= 1'b0;
                                mdio_o  <= 1'b1;
                                pre_cnt <= '0;
                                state   <= FS_PRE;
                                if (is_c45 && opq == OP_C45_RDINC) ptr <= ptr + 1'b1;
                            end else begin
                                mdio_o <= shreg[DW-1];
                                shreg  <= {shreg[DW-2:0], 1'b0};
                            end
                        end else begin
                            shreg <= dat_nxt;
                            if (dcnt == DAT_END) begin
                                pre_cnt <= '0;
                                state   <= FS_PRE;
                                if (ta == TA_WR_VALID) begin
                                    if (is_c45 && opq == OP_C45_ADDR) begin
                                        ptr <= dat_nxt;
                                    end else begin
                                        wr_req   <= 1'b1;
                                        req_c45  <= is_c45;
                                        req_dev  <= is_c45 ? raq : '0;
                                        req_adr  <= is_c45 ? ptr : {{(DW-RAW){1'b0}}, raq};
                                        req_wdat <= dat_nxt;
                                    end
                                end
                            end
                        end
                    end
                    default: state <= FS_PRE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Top level of the MDIO responder: synchroniser, frame decoder and bus bridge.
// Assumes an external pull-up on MDIO and a tri-state buffer fed by mdio_o/mdio_oe.
module mdio_mgmt_slave #(
    parameter int PRE_LEN     = 32,
    parameter int DW          = 16,
    parameter int PAW         = 5,
    parameter int RAW         = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PAW-1:0] phy_addr,
    input  logic           mdc,
    input  logic           mdio_i,
    output logic           mdio_o,
    output logic           mdio_oe,
    output logic           bus_stb,
    output logic           bus_we,
    output logic           bus_c45,
    output logic [RAW-1:0] bus_dev,
    output logic [DW-1:0]  bus_adr,
    output logic [DW-1:0]  bus_wdat,
    input  logic [DW-1:0]  bus_rdat,
    input  logic           bus_ack,
    output logic           wr_irq
);
    logic           bit_vld;
    logic           bit_val;
    logic           rd_req;
    logic           wr_req;
    logic           req_c45;
    logic [RAW-1:0] req_dev;
    logic [DW-1:0]  req_adr;
    logic [DW-1:0]  req_wdat;
    logic [DW-1:0]  rd_data;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_in (mdio_i),
        .bit_vld (bit_vld),
        .bit_val (bit_val)
    );

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN), .DW(DW), .PAW(PAW), .RAW(RAW)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .phy_addr (phy_addr),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .req_c45  (req_c45),
        .req_dev  (req_dev),
        .req_adr  (req_adr),
        .req_wdat (req_wdat)
    );

    mdio_bus_master #(.DW(DW), .RAW(RAW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .req_c45  (req_c45),
        .req_dev  (req_dev),
        .req_adr  (req_adr),
        .req_wdat (req_wdat),
        .bus_ack  (bus_ack),
        .bus_rdat (bus_rdat),
        .bus_stb  (bus_stb),
        .bus_we   (bus_we),
        .bus_c45  (bus_c45),
        .bus_dev  (bus_dev),
        .bus_adr  (bus_adr),
        .bus_wdat (bus_wdat),
        .rd_data  (rd_data),
        .wr_irq   (wr_irq)
    );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
// Protocol checker for mdio_mgmt_slave: bus handshake, interrupt timing and
// MDIO drive rules. Attached to every instance of the top module by bind.
module mdio_mgmt_slave_chk #(
    parameter int DW  = 16,
    parameter int RAW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mdio_o,
    input logic           mdio_oe,
    input logic           bus_stb,
    input logic           bus_we,
    input logic [RAW-1:0] bus_dev,
    input logic [DW-1:0]  bus_adr,
    input logic [DW-1:0]  bus_wdat,
    input logic           bus_ack,
    input logic           wr_irq
);
    AST_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb && !bus_ack |=> bus_stb && $stable(bus_we) && $stable(bus_adr)
                                && $stable(bus_wdat) && $stable(bus_dev)); // R11

    AST_IRQ_AFTER_WR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_irq |-> $past(bus_stb && bus_ack && bus_we)); // R6

    AST_WR_ACK_GIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb && bus_ack && bus_we |=> wr_irq); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_irq |=> !wr_irq); // R6

    AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o); // R5

    AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> !(bus_stb && bus_we)); // R5
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(.DW(DW), .RAW(RAW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .bus_stb  (bus_stb),
    .bus_we   (bus_we),
    .bus_dev  (bus_dev),
    .bus_adr  (bus_adr),
    .bus_wdat (bus_wdat),
    .bus_ack  (bus_ack),
    .wr_irq   (wr_irq)
);

// File: tb/sim_mdio_mgmt_slave.sv
`timescale 1ns/1ps
// Bench: behavioural host, register-space model and per-clock line monitor.
module sim_mdio_mgmt_slave;
    localparam logic [4:0] MY_ADDR = 5'h0B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        host_oe = 1'b0;
    logic        host_v = 1'b1;
    logic        mdio_line;
    logic        mdio_o, mdio_oe;
    logic        bus_stb, bus_we, bus_c45, wr_irq;
    logic [4:0]  bus_dev;
    logic [15:0] bus_adr, bus_wdat;
    logic [15:0] bus_rdat = '0;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    int cyc = 0;
    int ack_wait = 0;
    bit done = 0;
    bit oe_seen = 0;
    bit clash = 0;

    logic [15:0] regs [logic [21:0]];
    logic [37:0] wr_log [$];   // {key, data}
    int          rd_cnt = 0;

    always #2.5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (host_oe ? host_v : 1'b1);

    mdio_mgmt_slave u0 (
        .clk (clk), .rst_n (rst_n), .phy_addr (MY_ADDR),
        .mdc (mdc), .mdio_i (mdio_line), .mdio_o (mdio_o), .mdio_oe (mdio_oe),
        .bus_stb (bus_stb), .bus_we (bus_we), .bus_c45 (bus_c45), .bus_dev (bus_dev),
        .bus_adr (bus_adr), .bus_wdat (bus_wdat), .bus_rdat (bus_rdat),
        .bus_ack (bus_ack), .wr_irq (wr_irq)
    );

    function automatic logic [15:0] fill(input logic [21:0] key);
        return 16'h5A00 ^ key[15:0] ^ ({11'd0, key[20:16]} << 8);
    endfunction

    function automatic logic [15:0] peek(input logic [21:0] key);
        return regs.exists(key) ? regs[key] : fill(key);
    endfunction

    // Register-space model: acknowledge two cycles after a request.
    always @(posedge clk) begin
        bus_ack <= 1'b0;
        if (bus_stb && !bus_ack && rst_n) begin
            if (ack_wait == 2) begin
                ack_wait <= 0;
                bus_ack  <= 1'b1;
                if (bus_we) begin
                    regs[{bus_c45, bus_dev, bus_adr}] = bus_wdat;
                    wr_log.push_back({bus_c45, bus_dev, bus_adr, bus_wdat});
                end else begin
                    bus_rdat <= peek({bus_c45, bus_dev, bus_adr});
                    rd_cnt   <= rd_cnt + 1;
                end
            end else begin
                ack_wait <= ack_wait + 1;
            end
        end
        if (wr_irq) irq_cnt <= irq_cnt + 1;
    end

    // Per-clock line monitor: who drives MDIO and whether both do at once.
    always @(negedge clk) begin
        if (mdio_oe) oe_seen = 1;
        if (mdio_oe && host_oe) clash = 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One MDC period; returns the line level just before the rising edge.
    task automatic host_bit(input logic v, input logic drive, output logic smp);
        @(negedge clk);
        host_oe = drive;
        host_v  = v;
        repeat (4) @(negedge clk);
        smp = mdio_line;
        mdc = 1'b1;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic frame(input bit c45, input logic [1:0] op, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] dat,
                         input int pre, input bit rd,
                         output logic [15:0] got, output logic ta1, output logic ta2);
        logic s;
        logic [11:0] hdr;
        oe_seen = 0;
        clash   = 0;
        got     = '0;
        hdr     = {op, pa, ra};
        host_bit(1'b0, 1'b1, s);
        for (int i = 0; i < pre; i++) host_bit(1'b1, 1'b1, s);
        host_bit(1'b0, 1'b1, s);
        host_bit(!c45, 1'b1, s);
        for (int i = 11; i >= 0; i--) host_bit(hdr[i], 1'b1, s);
        if (rd) begin
            host_bit(1'b1, 1'b0, ta1);
            host_bit(1'b1, 1'b0, ta2);
            for (int i = 15; i >= 0; i--) begin
                host_bit(1'b1, 1'b0, s);
                got[i] = s;
            end
        end else begin
            host_bit(ta[1], 1'b1, ta1);
            host_bit(ta[0], 1'b1, ta2);
            for (int i = 15; i >= 0; i--) host_bit(dat[i], 1'b1, s);
        end
        host_bit(1'b1, 1'b0, s);
        host_bit(1'b1, 1'b0, s);
        chk(!clash, "R5", "no contention on MDIO", {31'd0, clash}, 32'd0);
        chk(!mdio_oe, "R5", "line released after frame", {31'd0, mdio_oe}, 32'd0);
    endtask

    // Compare bus writes seen since the last call with what is expected.
    task automatic expect_wr(input int n, input logic [21:0] key, input logic [15:0] dat,
                             input int irq_before, input string req);
        chk(wr_log.size() == n, req, "write cycle count", wr_log.size(), n);
        chk(irq_cnt - irq_before == n, "R6", "interrupt count", irq_cnt - irq_before, n);
        if (n == 1 && wr_log.size() == 1)
            chk(wr_log[0] == {key, dat}, req, "write address/data", wr_log[0][31:0], {key[15:0], dat});
        wr_log.delete();
    endtask

    initial begin
        logic [15:0] got;
        logic        t1, t2;
        int          i0;
        int          r0;

        repeat (5) @(negedge clk);
        chk(!mdio_oe && !bus_stb && !wr_irq, "R12", "outputs idle in reset",
            {29'd0, mdio_oe, bus_stb, wr_irq}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!mdio_oe && !bus_stb && !wr_irq, "R12", "outputs idle after reset",
            {29'd0, mdio_oe, bus_stb, wr_irq}, 32'd0);

        // R12: pointer starts at 0 -> extended read goes to address 0.
        frame(1, 2'b11, MY_ADDR, 5'd7, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(got == fill({1'b1, 5'd7, 16'h0000}), "R12", "pointer reset value read", got, fill({1'b1, 5'd7, 16'h0}));

        // R2: short-format write.
        i0 = irq_cnt;
        frame(0, 2'b01, MY_ADDR, 5'd5, 2'b10, 16'h1234, 32, 0, got, t1, t2);
        chk(!oe_seen, "R2", "no drive on write", {31'd0, oe_seen}, 32'd0);
        expect_wr(1, {1'b0, 5'd0, 16'd5}, 16'h1234, i0, "R2");

        // R5: short-format read back, turnaround and data timing.
        frame(0, 2'b10, MY_ADDR, 5'd5, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(t1 == 1'b1, "R5", "first turnaround bit undriven", {31'd0, t1}, 32'd1);
        chk(t2 == 1'b0, "R5", "second turnaround bit driven 0", {31'd0, t2}, 32'd0);
        chk(got == 16'h1234, "R5", "read data", got, 16'h1234);
        frame(0, 2'b10, MY_ADDR, 5'd9, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(got == fill({1'b0, 5'd0, 16'd9}), "R5", "read of untouched register", got, fill({1'b0, 5'd0, 16'd9}));

        // R3: foreign port address.
        i0 = irq_cnt; r0 = rd_cnt;
        frame(0, 2'b01, 5'h0C, 5'd5, 2'b10, 16'hDEAD, 32, 0, got, t1, t2);
        expect_wr(0, '0, '0, i0, "R3");
        frame(0, 2'b10, 5'h0C, 5'd5, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(!oe_seen, "R3", "no drive for foreign read", {31'd0, oe_seen}, 32'd0);
        chk(rd_cnt == r0, "R3", "no read cycle for foreign read", rd_cnt, r0);
        chk(got == 16'hFFFF, "R3", "line stays pulled up", got, 16'hFFFF);

        // R4: bad turnaround on writes.
        i0 = irq_cnt;
        frame(0, 2'b01, MY_ADDR, 5'd5, 2'b00, 16'hBAD0, 32, 0, got, t1, t2);
        frame(0, 2'b01, MY_ADDR, 5'd5, 2'b11, 16'hBAD1, 32, 0, got, t1, t2);
        frame(0, 2'b01, MY_ADDR, 5'd5, 2'b01, 16'hBAD2, 32, 0, got, t1, t2);
        expect_wr(0, '0, '0, i0, "R4");

        // R1: preamble boundary.
        i0 = irq_cnt;
        frame(0, 2'b01, MY_ADDR, 5'd6, 2'b10, 16'h0F0F, 31, 0, got, t1, t2);
        expect_wr(0, '0, '0, i0, "R1");
        frame(0, 2'b10, MY_ADDR, 5'd5, 2'b00, 16'h0, 20, 1, got, t1, t2);
        chk(!oe_seen, "R1", "short preamble read not answered", {31'd0, oe_seen}, 32'd0);
        i0 = irq_cnt;
        frame(0, 2'b01, MY_ADDR, 5'd6, 2'b10, 16'h0F0F, 32, 0, got, t1, t2);
        expect_wr(1, {1'b0, 5'd0, 16'd6}, 16'h0F0F, i0, "R1");

        // R10: illegal short-format opcodes.
        i0 = irq_cnt; r0 = rd_cnt;
        frame(0, 2'b00, MY_ADDR, 5'd6, 2'b10, 16'h1111, 32, 0, got, t1, t2);
        frame(0, 2'b11, MY_ADDR, 5'd6, 2'b10, 16'h2222, 32, 0, got, t1, t2);
        expect_wr(0, '0, '0, i0, "R10");
        frame(0, 2'b11, MY_ADDR, 5'd6, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(!oe_seen && rd_cnt == r0, "R10", "opcode 11 not answered", {31'd0, oe_seen}, 32'd0);

        // R7: extended address frame.
        i0 = irq_cnt;
        frame(1, 2'b00, MY_ADDR, 5'd3, 2'b10, 16'h0100, 32, 0, got, t1, t2);
        expect_wr(0, '0, '0, i0, "R7");

        // R8: extended write at pointer.
        i0 = irq_cnt;
        frame(1, 2'b01, MY_ADDR, 5'd3, 2'b10, 16'hBEEF, 32, 0, got, t1, t2);
        expect_wr(1, {1'b1, 5'd3, 16'h0100}, 16'hBEEF, i0, "R8");

        // R9: plain reads keep the pointer, incrementing read advances it.
        frame(1, 2'b11, MY_ADDR, 5'd3, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(got == 16'hBEEF, "R9", "extended read", got, 16'hBEEF);
        frame(1, 2'b11, MY_ADDR, 5'd3, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(got == 16'hBEEF, "R9", "pointer unchanged by plain read", got, 16'hBEEF);
        frame(1, 2'b10, MY_ADDR, 5'd3, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(got == 16'hBEEF, "R9", "incrementing read data", got, 16'hBEEF);
        frame(1, 2'b11, MY_ADDR, 5'd3, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(got == fill({1'b1, 5'd3, 16'h0101}), "R9", "read after increment", got, fill({1'b1, 5'd3, 16'h0101}));
        i0 = irq_cnt;
        frame(1, 2'b01, MY_ADDR, 5'd3, 2'b10, 16'hCAFE, 32, 0, got, t1, t2);
        expect_wr(1, {1'b1, 5'd3, 16'h0101}, 16'hCAFE, i0, "R9");

        // R4: extended address frame with bad turnaround leaves pointer.
        i0 = irq_cnt;
        frame(1, 2'b00, MY_ADDR, 5'd3, 2'b01, 16'h0777, 32, 0, got, t1, t2);
        expect_wr(0, '0, '0, i0, "R4");
        frame(1, 2'b11, MY_ADDR, 5'd3, 2'b00, 16'h0, 32, 1, got, t1, t2);
        chk(got == 16'hCAFE, "R4", "pointer kept after bad address frame", got, 16'hCAFE);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule